// File: doc/BRIEF.md
# I/O Base Register Decoder

This block holds the base address register of a bus target that needs a 32-byte window in I/O space, and decodes bus address phases against it. The host programs and reads the register through a simple configuration write port with a continuously valid read value. The upper 27 bits are writable. The low five bits are fixed so that a sizing probe (write all ones, read back) reveals the 32-byte requirement and marks the register as an I/O-space register.

During each address phase the decoder compares address bits 31 to 5 with the stored base. It does this only while I/O response is enabled and the bus command is an I/O read or an I/O write. A hit moves a two-state claim machine from `CLM_IDLE` to `CLM_CLAIM`, and the device-select claim output is high for as long as the machine stays in `CLM_CLAIM`. The transitions are:
- idle-to-claim: on a qualified hit.
- claim-to-claim: on another hit back to back.
- claim-to-idle: on any cycle without a hit.
- any-to-idle: forced while soft reset or stop is asserted.

Soft reset and stop never touch the stored base. Only the hard reset clears the base.

Top module: `iobar_decoder`

## Requirements
- R1: While `hrst_n` is low and after it is released, `cfg_rdata` reads 32'h0000_0001 and `devsel_claim` is low.
- R2: A cycle with `cfg_wr` high stores `cfg_wdata[31:5]` as the base, and `cfg_rdata[31:5]` shows it from the next clock.
- R3: `cfg_rdata[4:1]` always read zero and `cfg_rdata[0]` always reads one, whatever is written. After writing 32'hFFFF_FFFF, the read value is 32'hFFFF_FFE1.
- R4: With `io_en` low, `devsel_claim` stays low for every address phase.
- R5: Only `cmd` 4'b0010 (I/O read) and 4'b0011 (I/O write) can produce a claim. Every other code leaves `devsel_claim` low.
- R6: A claim requires `ad[31:5]` to equal the stored base. `ad[4:0]` has no effect on the decision.
- R7: A qualified hit sampled at a clock edge (with `addr_phase` high) makes `devsel_claim` high in the following cycle. `devsel_claim` stays high one cycle per hit and falls in the cycle after a cycle without a hit.
- R8: `soft_rst` or `stop_req` leaves the stored base unchanged. When either is high at an edge, `devsel_claim` is low in the following cycle, even if that edge saw a hit.
- R9: Without `addr_phase` high, no claim is produced, even with a matching address and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| hrst_n | input | 1 | Hard reset, active low, asynchronous assert |
| soft_rst | input | 1 | Soft reset: drops a pending claim, keeps base |
| stop_req | input | 1 | Stop control: drops a pending claim, keeps base |
| cfg_wr | input | 1 | Configuration write strobe for the base register |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current register read value |
| io_en | input | 1 | I/O response enable from the command register |
| ad | input | 32 | Address/data bus, address during address phase |
| cmd | input | 4 | Bus command during address phase |
| addr_phase | input | 1 | High for the cycle that carries an address phase |
| devsel_claim | output | 1 | Device-select claim, high the cycle after a hit |

## Verification
The assertions assume that `cfg_wr` is not high in the same cycle as an address phase. The comparison is therefore always made against a stable base. The bench keeps every configuration write in a cycle of its own, with `addr_phase` low. The assertions also assume that the inputs are settled at each rising edge. The bench changes every input one nanosecond after the edge and checks the outputs on the falling edge.

// File: rtl/iobar_pkg.sv
package iobar_pkg;

    localparam logic [3:0] CMD_IO_RD = 4'b0010;
    localparam logic [3:0] CMD_IO_WR = 4'b0011;

    typedef enum logic [0:0] {
        CLM_IDLE  = 1'b0,
        CLM_CLAIM = 1'b1
    } claim_state_e;

    function automatic logic is_io_cmd(input logic [3:0] c);
        return (c == CMD_IO_RD) || (c == CMD_IO_WR);
    endfunction

endpackage

// File: rtl/iobar_reg.sv
module iobar_reg #(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 5
) (
    input  logic                       clk,
    input  logic                       hrst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_data,
    output logic [ADDR_W-WIN_LOG2-1:0] base_q,
    output logic [ADDR_W-1:0]          rd_data
);
    localparam int BASE_W = ADDR_W - WIN_LOG2;
    // Bit 0 marks I/O space; bits above it within the window are fixed zero.
    localparam logic [WIN_LOG2-1:0] LOW_FIXED = {{(WIN_LOG2-1){1'b0}}, 1'b1};

    logic unused_low_wr;
    assign unused_low_wr = ^wr_data[WIN_LOG2-1:0];

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            base_q <= '0;
        end else if (wr_en) begin
            base_q <= wr_data[ADDR_W-1:WIN_LOG2];
        end
    end

    always_comb begin
        rd_data = {base_q, LOW_FIXED};
    end

    initial begin
        if (BASE_W < 1) $error("window larger than address");
    end
endmodule

// File: rtl/iobar_match.sv
module iobar_match
    import iobar_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 5
) (
    input  logic                       addr_phase,
    input  logic                       io_en,
    input  logic [3:0]                 cmd,
    input  logic [ADDR_W-1:0]          ad,
    input  logic [ADDR_W-WIN_LOG2-1:0] base,
    output logic                       hit
);
    logic unused_low_ad;
    assign unused_low_ad = ^ad[WIN_LOG2-1:0];

    logic addr_eq;

    always_comb begin
        addr_eq = (ad[ADDR_W-1:WIN_LOG2] == base);
        hit     = addr_phase && io_en && is_io_cmd(cmd) && addr_eq;
    end
endmodule

// File: rtl/iobar_claim_fsm.sv
module iobar_claim_fsm
    import iobar_pkg::*;
(
    input  logic clk,
    input  logic hrst_n,
    input  logic quiesce,
    input  logic hit,
    output logic claim
);
    claim_state_e state_q, state_d;

    always_ff @(posedge clk or negedge hrst_n) begin
        if (!hrst_n) begin
            state_q <= CLM_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLM_IDLE:  state_d = (hit && !quiesce) ? CLM_CLAIM : CLM_IDLE;
            CLM_CLAIM: state_d = (hit && !quiesce) ? CLM_CLAIM : CLM_IDLE;
            default:   state_d = CLM_IDLE;
        endcase
    end

    always_comb begin
        claim = (state_q == CLM_CLAIM);
    end
endmodule

// File: rtl/iobar_decoder.sv
module iobar_decoder #(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 5
) (
    input  logic              clk,
    input  logic              hrst_n,
    input  logic              soft_rst,
    input  logic              stop_req,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              io_en,
    input  logic [ADDR_W-1:0] ad,
    input  logic [3:0]        cmd,
    input  logic              addr_phase,
    output logic              devsel_claim
);
    localparam int BASE_W = ADDR_W - WIN_LOG2;

    logic [BASE_W-1:0] base_q;
    logic              hit;
    logic              quiesce;

    assign quiesce = soft_rst || stop_req;

    iobar_reg #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_reg (
        .clk     (clk),
        .hrst_n  (hrst_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .base_q  (base_q),
        .rd_data (cfg_rdata)
    );

    iobar_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_match (
        .addr_phase (addr_phase),
        .io_en      (io_en),
        .cmd        (cmd),
        .ad         (ad),
        .base       (base_q),
        .hit        (hit)
    );

    iobar_claim_fsm u_fsm (
        .clk     (clk),
        .hrst_n  (hrst_n),
        .quiesce (quiesce),
        .hit     (hit),
        .claim   (devsel_claim)
    );
endmodule

// File: rtl/iobar_decoder_chk.sv
module iobar_decoder_chk
    import iobar_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_LOG2 = 5
) (
    input logic              clk,
    input logic              hrst_n,
    input logic              soft_rst,
    input logic              stop_req,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic [ADDR_W-1:0] cfg_rdata,
    input logic              io_en,
    input logic [ADDR_W-1:0] ad,
    input logic [3:0]        cmd,
    input logic              addr_phase,
    input logic              devsel_claim
);
    localparam logic [WIN_LOG2-1:0] LOW_FIXED = {{(WIN_LOG2-1){1'b0}}, 1'b1};

    // R3: fixed low bits
    a_r3_low_bits: assert property (@(posedge clk) disable iff (!hrst_n)
        cfg_rdata[WIN_LOG2-1:0] == LOW_FIXED);

    // R2: written base visible next clock
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!hrst_n)
        cfg_wr |=> cfg_rdata[ADDR_W-1:WIN_LOG2] == $past(cfg_wdata[ADDR_W-1:WIN_LOG2]));

    // R7: qualified hit produces a claim next cycle
    a_r7_claim_follows_hit: assert property (@(posedge clk) disable iff (!hrst_n)
        (addr_phase && io_en && is_io_cmd(cmd) && !soft_rst && !stop_req && !cfg_wr
         && ad[ADDR_W-1:WIN_LOG2] == cfg_rdata[ADDR_W-1:WIN_LOG2]) |=> devsel_claim);

    // R4, R5, R9: a claim needs an enabled I/O address phase one cycle earlier
    a_r4_r5_r9_claim_cause: assert property (@(posedge clk) disable iff (!hrst_n)
        devsel_claim |-> $past(addr_phase && io_en && is_io_cmd(cmd)));

    // R6: address mismatch gives no claim
    a_r6_mismatch_quiet: assert property (@(posedge clk) disable iff (!hrst_n)
        (!cfg_wr && ad[ADDR_W-1:WIN_LOG2] != cfg_rdata[ADDR_W-1:WIN_LOG2]) |=> !devsel_claim);

    // R8: soft reset / stop keep the base and drop a claim
    a_r8_base_kept: assert property (@(posedge clk) disable iff (!hrst_n)
        ((soft_rst || stop_req) && !cfg_wr) |=> $stable(cfg_rdata));

    a_r8_claim_dropped: assert property (@(posedge clk) disable iff (!hrst_n)
        (soft_rst || stop_req) |=> !devsel_claim);
endmodule

bind iobar_decoder iobar_decoder_chk u_chk (
    .clk          (clk),
    .hrst_n       (hrst_n),
    .soft_rst     (soft_rst),
    .stop_req     (stop_req),
    .cfg_wr       (cfg_wr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .io_en        (io_en),
    .ad           (ad),
    .cmd          (cmd),
    .addr_phase   (addr_phase),
    .devsel_claim (devsel_claim)
);

// File: tb/test_iobar_decoder.sv
module test_iobar_decoder;

    logic        clk = 1'b0;
    logic        hrst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        stop_req = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_en = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cmd = '0;
    logic        addr_phase = 1'b0;
    logic        devsel_claim;

    always #2.5 clk = ~clk;

    iobar_decoder i_iobar_decoder (
        .clk(clk), .hrst_n(hrst_n), .soft_rst(soft_rst), .stop_req(stop_req),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_en(io_en), .ad(ad), .cmd(cmd), .addr_phase(addr_phase),
        .devsel_claim(devsel_claim)
    );

    typedef struct {
        int    due;
        logic  exp;
        string tag;
    } item_t;

    item_t       sb_q[$];
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fails = 0;
    logic [26:0] mbase = '0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard entries due in this cycle
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, {31'b0, devsel_claim}, {31'b0, it.exp});
        end
    end

    // Driver: one bus cycle, expectation pushed for the next cycle
    task automatic bus_cycle(input logic ap, input logic en, input logic [3:0] c,
                             input logic [31:0] a, input logic sft, input logic stp,
                             input string tag);
        item_t it;
        @(posedge clk);
        #1;
        addr_phase = ap; io_en = en; cmd = c; ad = a;
        soft_rst = sft; stop_req = stp; cfg_wr = 1'b0;
        it.due = cyc + 1;
        it.exp = ap && en && (c == 4'b0010 || c == 4'b0011) &&
                 (a[31:5] == mbase) && !sft && !stp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic cfg_write(input logic [31:0] d);
        @(posedge clk);
        #1;
        addr_phase = 1'b0; soft_rst = 1'b0; stop_req = 1'b0;
        cfg_wr = 1'b1; cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
        mbase = d[31:5];
    endtask

    task automatic read_check(input string tag, input logic [31:0] exp);
        @(negedge clk);
        check(tag, cfg_rdata, exp);
    endtask

    initial begin
        #(5 * 20000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset rdata", cfg_rdata, 32'h0000_0001);
        check("R1 reset claim", {31'b0, devsel_claim}, 32'h0);
        @(posedge clk); #1; hrst_n = 1'b1;
        read_check("R1 after release", 32'h0000_0001);

        cfg_write(32'hFFFF_FFFF);
        read_check("R3 all-ones probe", 32'hFFFF_FFE1);
        cfg_write(32'h1234_5678);
        read_check("R2 R3 base write", 32'h1234_5661);

        bus_cycle(1, 1, 4'b0010, 32'h1234_567F, 0, 0, "R6 R7 io read hit low bits ignored");
        bus_cycle(0, 1, 4'b0010, 32'h0, 0, 0, "R7 claim falls");
        bus_cycle(1, 1, 4'b0011, 32'h1234_5660, 0, 0, "R5 io write hit");
        bus_cycle(1, 1, 4'b0010, 32'h1234_5661, 0, 0, "R7 back-to-back hit");
        bus_cycle(1, 1, 4'b0110, 32'h1234_5660, 0, 0, "R5 memory read ignored");
        bus_cycle(1, 1, 4'b1010, 32'h1234_5660, 0, 0, "R5 config read ignored");
        bus_cycle(1, 1, 4'b0000, 32'h1234_5660, 0, 0, "R5 code 0 ignored");
        bus_cycle(1, 0, 4'b0010, 32'h1234_5660, 0, 0, "R4 io disabled");
        bus_cycle(1, 1, 4'b0010, 32'h1234_5640, 0, 0, "R6 bit5 mismatch");
        bus_cycle(1, 1, 4'b0010, 32'h9234_5660, 0, 0, "R6 bit31 mismatch");
        bus_cycle(0, 1, 4'b0010, 32'h1234_5660, 0, 0, "R9 no address phase");
        bus_cycle(1, 1, 4'b0010, 32'h1234_5660, 0, 0, "R7 hit before quiesce");
        bus_cycle(1, 1, 4'b0010, 32'h1234_5660, 1, 0, "R8 soft reset drops hit");
        bus_cycle(1, 1, 4'b0011, 32'h1234_5660, 0, 1, "R8 stop drops hit");
        bus_cycle(0, 0, 4'b0000, 32'h0, 1, 1, "R8 quiesce idle");
        bus_cycle(0, 0, 4'b0000, 32'h0, 0, 0, "R8 idle");
        read_check("R8 base kept", 32'h1234_5661);
        bus_cycle(1, 1, 4'b0011, 32'h1234_567E, 0, 0, "R8 claim after quiesce");
        bus_cycle(0, 0, 4'b0000, 32'h0, 0, 0, "R7 idle tail");

        cfg_write(32'h0000_ABE0);
        read_check("R2 second base", 32'h0000_ABE1);
        bus_cycle(1, 1, 4'b0010, 32'h0000_ABFF, 0, 0, "R6 new base hit");
        bus_cycle(1, 1, 4'b0010, 32'h1234_5660, 0, 0, "R6 old base miss");
        bus_cycle(0, 0, 4'b0000, 32'h0, 0, 0, "R7 idle");

        @(posedge clk); #1; hrst_n = 1'b0; mbase = '0;
        @(negedge clk);
        check("R1 hard reset rdata", cfg_rdata, 32'h0000_0001);
        check("R1 hard reset claim", {31'b0, devsel_claim}, 32'h0);
        @(posedge clk); #1; hrst_n = 1'b1;
        bus_cycle(1, 1, 4'b0010, 32'h0000_001C, 0, 0, "R1 cleared base hit");
        bus_cycle(0, 0, 4'b0000, 32'h0, 0, 0, "R7 final idle");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule